// File: doc/BRIEF.md
# Low-voltage reset sequencer

This block produces the reset timing that follows a supply brown-out. It watches two comparator flags: one that says the supply has fallen below the falling trip level, and one that says the supply is back above the rising trip level. When the supply falls, the block pulls the external reset pin low, gates the clocks to the CPU and the other modules, and sends a one-cycle flag pulse to the reset status register.

Once the supply is back above the rising trip level, the block counts an oscillator-settling delay on the reference clock. When that delay ends, the module clocks come back on. The reset pin is released a fixed number of cycles later, and after a longer offset the CPU gets a single-cycle release strobe that starts its reset-vector fetch. A new fall below the falling trip level at any point starts the whole sequence again from the beginning.

Both comparator flags are asynchronous to the clock, so each passes through a synchronizer of `SYNC_STAGES` flops. A change at an input takes effect `SYNC_STAGES + 1` clock edges later.

Top module: `brownout_reset_seq`

## Requirements
- R1: While `rst_n` is low and after it is released with the supply healthy, `rst_pin_n_o`=1, `mod_clk_en_o`=1, `cpu_release_o`=0 and `lvi_flag_o`=0.
- R2: When `supply_low_i` rises, the effect appears on the third rising edge (SYNC_STAGES+1 with the default of 2). From then on `rst_pin_n_o`=0 and `mod_clk_en_o`=0, and `lvi_flag_o` is high for exactly that one cycle.
- R3: The reset pin stays low and the clocks stay gated for as long as `supply_low_i`=1 or `supply_ok_i`=0.
- R4: The settling count starts when `supply_low_i`=0 and `supply_ok_i`=1 both hold. `mod_clk_en_o` first reads 1 in cycle SETTLE_CYCLES+SYNC_STAGES+1 (4099 by default), counting the cycle in which the inputs changed as 0.
- R5: `rst_pin_n_o` returns to 1 exactly PIN_OFFSET (32) cycles after `mod_clk_en_o` first reads 1.
- R6: `cpu_release_o` is a single-cycle pulse, exactly CPU_OFFSET (64) cycles after `mod_clk_en_o` first reads 1, once per completed sequence.
- R7: When `supply_low_i` rises during settling, pin hold or CPU hold, the sequence goes back to the low-supply state. It pulses `lvi_flag_o` again, clears the counter and gives no CPU release. The next recovery then takes the full R4 timing.
- R8: If `supply_ok_i` drops during settling while `supply_low_i` stays 0, the block returns to waiting without an `lvi_flag_o` pulse, and the count restarts from zero on the next recovery.
- R9: Once settling has completed, and in the idle state, changes of `supply_ok_i` alone have no effect on any output.
- R10: `rst_pin_n_o`=1 always implies `mod_clk_en_o`=1, and `cpu_release_o`=1 only while `rst_pin_n_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that the delays are counted on |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously inside |
| supply_low_i | input | 1 | Comparator flag: supply is below the falling trip level (asynchronous) |
| supply_ok_i | input | 1 | Comparator flag: supply is above the rising trip level (asynchronous) |
| rst_pin_n_o | output | 1 | Drive for the external reset pin, 0 = hold in reset |
| mod_clk_en_o | output | 1 | Clock enable for the CPU and modules |
| cpu_release_o | output | 1 | One-cycle strobe that starts the CPU reset-vector fetch |
| lvi_flag_o | output | 1 | One-cycle pulse that sets the low-voltage flag in the status register |

## Verification
The assertions check on every cycle the relations between the outputs that hold in any phase. Both strobes are single-cycle, the pin is released only with clocks running, a flag pulse always coincides with reset asserted and clocks gated, and the pin and CPU releases land exactly 32 and 64 cycles after the clock enable rises. The exact settling length, the synchronizer latency, and the restart behaviour when a new drop lands in each phase depend on the history of the inputs. Only the directed scenarios show these, because they drive brown-outs and dips at chosen points and count cycles to each output edge.

// File: rtl/lvr_pkg.sv
package lvr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_LOW_SUPPLY = 3'd1,
    ST_SETTLE     = 3'd2,
    ST_PIN_HOLD   = 3'd3,
    ST_CPU_HOLD   = 3'd4
  } lvr_state_t;

endpackage

// File: rtl/lvr_rst_sync.sv
module lvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= 1'b0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/lvr_flag_sync.sv
module lvr_flag_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/lvr_phase_counter.sv
module lvr_phase_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/lvr_seq_fsm.sv
module lvr_seq_fsm
  import lvr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4096,
  parameter int PIN_OFFSET    = 32,
  parameter int CPU_OFFSET    = 64,
  parameter int CNT_W         = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_s_i,
  input  logic             ok_s_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             pin_n_o,
  output logic             clk_en_o,
  output logic             cpu_rel_o,
  output logic             lvi_o
);

  // The counter runs without a break from the start of settling to the CPU release.
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] PIN_LAST    = CNT_W'(SETTLE_CYCLES + PIN_OFFSET - 1);
  localparam logic [CNT_W-1:0] CPU_LAST    = CNT_W'(SETTLE_CYCLES + CPU_OFFSET - 1);

  lvr_state_t state_q, state_d;
  logic       lvi_q, lvi_d;
  logic       cpu_q, cpu_d;

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    lvi_d     = 1'b0;
    cpu_d     = 1'b0;
    if (low_s_i && (state_q != ST_LOW_SUPPLY)) begin
      // a fall below the falling trip restarts from any phase
      state_d   = ST_LOW_SUPPLY;
      cnt_clr_o = 1'b1;
      lvi_d     = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_clr_o = 1'b1;
        end
        ST_LOW_SUPPLY: begin
          cnt_clr_o = 1'b1;
          if (!low_s_i && ok_s_i) state_d = ST_SETTLE;
        end
        ST_SETTLE: begin
          if (!ok_s_i) begin
            state_d   = ST_LOW_SUPPLY;
            cnt_clr_o = 1'b1;
          end else begin
            cnt_inc_o = 1'b1;
            if (cnt_i == SETTLE_LAST) state_d = ST_PIN_HOLD;
          end
        end
        ST_PIN_HOLD: begin
          cnt_inc_o = 1'b1;
          if (cnt_i == PIN_LAST) state_d = ST_CPU_HOLD;
        end
        ST_CPU_HOLD: begin
          if (cnt_i == CPU_LAST) begin
            state_d   = ST_IDLE;
            cnt_clr_o = 1'b1;
            cpu_d     = 1'b1;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
        default: begin
          state_d   = ST_LOW_SUPPLY;
          cnt_clr_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvi_q   <= 1'b0;
      cpu_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lvi_q   <= lvi_d;
      cpu_q   <= cpu_d;
    end
  end

  always_comb begin
    pin_n_o   = (state_q == ST_IDLE) || (state_q == ST_CPU_HOLD);
    clk_en_o  = (state_q == ST_IDLE) || (state_q == ST_PIN_HOLD) ||
                (state_q == ST_CPU_HOLD);
    cpu_rel_o = cpu_q;
    lvi_o     = lvi_q;
  end

endmodule

// File: rtl/brownout_reset_seq.sv
module brownout_reset_seq #(
  parameter int SETTLE_CYCLES = 4096,
  parameter int PIN_OFFSET    = 32,
  parameter int CPU_OFFSET    = 64,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low_i,
  input  logic supply_ok_i,
  output logic rst_pin_n_o,
  output logic mod_clk_en_o,
  output logic cpu_release_o,
  output logic lvi_flag_o
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + CPU_OFFSET + 1);

  logic             rst_n_sync;
  logic             low_s;
  logic             ok_s;
  logic             cnt_clr;
  logic             cnt_inc;
  logic [CNT_W-1:0] cnt;

  lvr_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_sync)
  );

  lvr_flag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) low_sync_i (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d_i   (supply_low_i),
    .q_o   (low_s)
  );

  lvr_flag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) ok_sync_i (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d_i   (supply_ok_i),
    .q_o   (ok_s)
  );

  lvr_phase_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  lvr_seq_fsm #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .PIN_OFFSET    (PIN_OFFSET),
    .CPU_OFFSET    (CPU_OFFSET),
    .CNT_W         (CNT_W)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .low_s_i   (low_s),
    .ok_s_i    (ok_s),
    .cnt_i     (cnt),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .pin_n_o   (rst_pin_n_o),
    .clk_en_o  (mod_clk_en_o),
    .cpu_rel_o (cpu_release_o),
    .lvi_o     (lvi_flag_o)
  );

endmodule

// File: rtl/brownout_reset_seq_chk.sv
module brownout_reset_seq_chk #(
  parameter int PIN_OFFSET = 32,
  parameter int CPU_OFFSET = 64
) (
  input logic clk,
  input logic rst_n,
  input logic rst_pin_n_o,
  input logic mod_clk_en_o,
  input logic cpu_release_o,
  input logic lvi_flag_o
);

  localparam int CW = $clog2(CPU_OFFSET + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  // cycles for which the clock enable has been high, saturating
  logic [CW-1:0] en_age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  en_age_q <= '0;
    else if (!mod_clk_en_o)      en_age_q <= '0;
    else if (en_age_q != CMAX)   en_age_q <= en_age_q + 1'b1;
  end

  p_lvi_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lvi_flag_o |=> !lvi_flag_o);

  p_lvi_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lvi_flag_o |-> (!rst_pin_n_o && !mod_clk_en_o));

  p_clk_before_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_clk_en_o) |-> !rst_pin_n_o);

  p_pin_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pin_n_o) |-> (en_age_q == CW'(PIN_OFFSET)));

  p_cpu_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release_o |=> !cpu_release_o);

  p_cpu_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release_o |-> (en_age_q == CW'(CPU_OFFSET)));

  p_pin_needs_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pin_n_o |-> mod_clk_en_o);

  p_cpu_pin_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release_o |-> rst_pin_n_o);

endmodule

bind brownout_reset_seq brownout_reset_seq_chk #(
  .PIN_OFFSET (PIN_OFFSET),
  .CPU_OFFSET (CPU_OFFSET)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .rst_pin_n_o   (rst_pin_n_o),
  .mod_clk_en_o  (mod_clk_en_o),
  .cpu_release_o (cpu_release_o),
  .lvi_flag_o    (lvi_flag_o)
);

// File: tb/brownout_reset_seq_tb_top.sv
`timescale 1ns/1ps
module brownout_reset_seq_tb_top;

  localparam int SETTLE = 4096;
  localparam int PIN_OFF = 32;
  localparam int CPU_OFF = 64;
  localparam int LAT = 3;                     // SYNC_STAGES + 1
  localparam int EXP_CLK = SETTLE + LAT;      // 4099
  localparam int EXP_PIN = EXP_CLK + PIN_OFF; // 4131
  localparam int EXP_CPU = EXP_CLK + CPU_OFF; // 4163

  logic clk = 1'b0;
  logic rst_n;
  logic supply_low;
  logic supply_ok;
  logic pin_n, clk_en, cpu_rel, lvi;

  int checks = 0;
  int errors = 0;
  int cnt_lvi = 0;
  int cnt_cpu = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  brownout_reset_seq dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_low_i  (supply_low),
    .supply_ok_i   (supply_ok),
    .rst_pin_n_o   (pin_n),
    .mod_clk_en_o  (clk_en),
    .cpu_release_o (cpu_rel),
    .lvi_flag_o    (lvi)
  );

  // strobes counted from the values held just before each edge
  always @(posedge clk) begin
    if (lvi)     cnt_lvi <= cnt_lvi + 1;
    if (cpu_rel) cnt_cpu <= cnt_cpu + 1;
  end

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic outs(string req, int e_pin, int e_clk, int e_cpu, int e_lvi);
    check_eq({req, " pin"}, int'(pin_n), e_pin);
    check_eq({req, " clk_en"}, int'(clk_en), e_clk);
    check_eq({req, " cpu_rel"}, int'(cpu_rel), e_cpu);
    check_eq({req, " lvi"}, int'(lvi), e_lvi);
  endtask

  // drive a fall below the falling trip and check the entry into reset
  task automatic brownout(string req);
    int l0 = cnt_lvi;
    supply_low = 1'b1;
    supply_ok  = 1'b0;
    cyc(LAT);
    outs({req, " entry"}, 0, 0, 0, 1);
    cyc(1);
    check_eq({req, " lvi one cycle"}, int'(lvi), 0);
    check_eq({req, " lvi count"}, cnt_lvi - l0, 1);
  endtask

  // recover the supply and time every output edge from the input change
  task automatic measure(string req);
    int f_clk = -1, f_pin = -1, f_cpu = -1, cpu_hi = 0, bad = 0;
    supply_low = 1'b0;
    supply_ok  = 1'b1;
    for (int k = 1; k <= EXP_CPU + 40; k++) begin
      @(negedge clk);
      if (f_clk < 0 && clk_en)  f_clk = k;
      if (f_pin < 0 && pin_n)   f_pin = k;
      if (f_cpu < 0 && cpu_rel) f_cpu = k;
      if (cpu_rel) cpu_hi++;
      if (pin_n && !clk_en) bad++;
    end
    check_eq({req, " R4 first clk_en cycle"}, f_clk, EXP_CLK);
    check_eq({req, " R5 pin release cycle"}, f_pin, EXP_PIN);
    check_eq({req, " R6 cpu release cycle"}, f_cpu, EXP_CPU);
    check_eq({req, " R6 cpu pulse width"}, cpu_hi, 1);
    check_eq({req, " R10 pin high with clocks gated"}, bad, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    supply_low = 1'b0;
    supply_ok  = 1'b1;
    cyc(3);
    outs("R1 in reset", 1, 1, 0, 0);
    rst_n = 1'b1;
    cyc(8);
    outs("R1 after reset", 1, 1, 0, 0);
  endtask

  task automatic t_basic();
    supply_low = 1'b1;
    supply_ok  = 1'b0;
    cyc(LAT - 1);
    check_eq("R2 pin before latency", int'(pin_n), 1);
    cyc(1);
    outs("R2 entry", 0, 0, 0, 1);
    cyc(1);
    check_eq("R2 lvi single", int'(lvi), 0);
    cyc(40);
    outs("R3 held low", 0, 0, 0, 0);
    supply_low = 1'b0;              // between trips: still not ok
    cyc(30);
    outs("R3 between trips", 0, 0, 0, 0);
    begin
      int c0 = cnt_cpu;
      measure("R4 basic");
      check_eq("R6 one release per sequence", cnt_cpu - c0, 1);
    end
  endtask

  task automatic t_restart_settle();
    brownout("R7 setup");
    supply_low = 1'b0;
    supply_ok  = 1'b1;
    cyc(1000);
    outs("R7 in settle", 0, 0, 0, 0);
    begin
      int l0 = cnt_lvi;
      supply_low = 1'b1;
      cyc(LAT);
      outs("R7 restart in settle", 0, 0, 0, 1);
      cyc(5);
      check_eq("R7 settle restart lvi count", cnt_lvi - l0, 1);
    end
    measure("R7 after settle restart");
  endtask

  task automatic t_restart_pin();
    int c0;
    brownout("R7 setup pin");
    supply_low = 1'b0;
    supply_ok  = 1'b1;
    cyc(EXP_CLK + 10);
    outs("R7 in pin hold", 0, 1, 0, 0);
    c0 = cnt_cpu;
    supply_low = 1'b1;
    cyc(LAT);
    outs("R7 restart in pin hold", 0, 0, 0, 1);
    cyc(80);
    check_eq("R7 no release after pin restart", cnt_cpu - c0, 0);
    measure("R7 after pin restart");
  endtask

  task automatic t_restart_cpu();
    int c0;
    brownout("R7 setup cpu");
    supply_low = 1'b0;
    supply_ok  = 1'b1;
    cyc(EXP_PIN + 5);
    outs("R7 in cpu hold", 1, 1, 0, 0);
    c0 = cnt_cpu;
    supply_low = 1'b1;
    cyc(LAT);
    outs("R7 restart in cpu hold", 0, 0, 0, 1);
    cyc(60);
    check_eq("R7 no release after cpu restart", cnt_cpu - c0, 0);
    measure("R7 after cpu restart");
  endtask

  task automatic t_ok_dip();
    int l0;
    brownout("R8 setup");
    supply_low = 1'b0;
    supply_ok  = 1'b1;
    cyc(2000);
    l0 = cnt_lvi;
    supply_ok = 1'b0;
    cyc(LAT + 20);
    outs("R8 dip during settle", 0, 0, 0, 0);
    check_eq("R8 no lvi on dip", cnt_lvi - l0, 0);
    measure("R8 count restarts");
  endtask

  task automatic t_ignore();
    int l0;
    brownout("R9 setup");
    supply_low = 1'b0;
    supply_ok  = 1'b1;
    cyc(EXP_CLK + 6);
    supply_ok = 1'b0;               // dip after settling is done
    cyc(EXP_PIN - 1 - (EXP_CLK + 6));
    check_eq("R9 pin still held", int'(pin_n), 0);
    check_eq("R9 clocks stay on", int'(clk_en), 1);
    cyc(1);
    check_eq("R9 pin released on time", int'(pin_n), 1);
    cyc(CPU_OFF - PIN_OFF);
    check_eq("R9 cpu release on time", int'(cpu_rel), 1);
    supply_ok = 1'b1;
    cyc(10);
    l0 = cnt_lvi;
    supply_ok = 1'b0;               // dip in idle
    cyc(25);
    outs("R9 idle dip", 1, 1, 0, 0);
    check_eq("R9 no lvi in idle", cnt_lvi - l0, 0);
    supply_ok = 1'b1;
    cyc(5);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_restart_settle();
    t_restart_pin();
    t_restart_cpu();
    t_ok_dip();
    t_ignore();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule